// File: doc/BRIEF.md
# Descriptor Chain DMA Sequencer

This block serves one packet channel, configured at elaboration as a receive or a transmit channel. It walks a linked list of buffer descriptors in a word-addressed memory. When started, it reads the current descriptor pointer from a shared channel control block and loads that descriptor's buffer length and 32-bit buffer address. It then offers the buffer to the packet datapath and holds it there until the datapath reports a result. It records the result in the descriptor and advances the list head with one write to the control block. Finally it signals software with a one-cycle interrupt that carries the channel's wake mask.

A zero pointer means that no descriptor is available. On a receive channel the block then bumps a missed-packet counter in the control block and tells the datapath to drop the packet. On a transmit channel it parks until software starts it again. A transmit channel keeps following the chain after each packet. A receive channel waits for the next packet arrival. All memory traffic goes through a valid/ready request port that allows one request in flight.

Top module: `dcs_chain_seq`

## Requirements
- R1: A `go` pulse on an idle channel makes the block read control block word 1 (the list head). A head value of zero means no descriptor, and the channel presents no buffer.
- R2: For a non-zero head, the block reads descriptor words 5 (length), 6 (address low) and 7 (address high). It then raises `buf_valid` with `buf_addr` = {high,low} and `buf_len` = length, and holds all three steady until `dp_done`.
- R3: A descriptor whose length is below 4, or whose low address has either of bits 1:0 set, is never presented. The block writes 0x6400 to descriptor word 3 and 0 to word 4. On a receive channel it also pulses `discard` once.
- R4: On `dp_done`, the block writes `dp_used` to descriptor word 4 and `dp_status` to descriptor word 3.
- R5: After the completion write, the block reads descriptor word 0 (the link) and stores it into control block word 1 with a single write.
- R6: The block then reads control block word 4 and pulses `irq` for exactly one cycle with `irq_mask` equal to that word. The completion word is always in memory before `irq` rises.
- R7: On a receive channel, a zero head makes the block read control block word 5 and write it back incremented by one. It pulses `discard` once, raises no interrupt, and returns to idle.
- R8: On a transmit channel, a zero head sends the channel idle without touching control block word 5. It then issues no memory request, even after the head becomes non-zero, until the next `go`.
- R9: After each interrupt, a transmit channel reads the head again and continues down the chain without a new `go`. A receive channel returns to idle and waits for `go`.
- R10: At most one memory request is in flight. `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` stay steady until `mem_ready`. Read data is taken on `mem_rvalid`.
- R11: While reset is asserted, `mem_req`, `buf_valid`, `irq` and `discard` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cb_base | input | AW | Word address of the channel control block |
| go | input | 1 | Start pulse: packet arrival (receive) or software enable (transmit) |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| buf_valid | output | 1 | A buffer is offered to the datapath |
| buf_addr | output | 2*DW | Buffer word address |
| buf_len | output | DW | Buffer length in words |
| dp_done | input | 1 | Datapath finished with the buffer |
| dp_used | input | DW | Words the datapath used |
| dp_status | input | DW | Completion word from the datapath |
| discard | output | 1 | One-cycle request to drop the incoming packet |
| irq | output | 1 | One-cycle interrupt pulse |
| irq_mask | output | DW | Wake mask carried with the interrupt |

## Verification
The bench builds two copies with the default widths (16-bit data and address, minimum length 4, two alignment bits). One copy is a receive channel whose memory model accepts requests only on alternate cycles. The other is a transmit channel with a memory that is always ready. The stalling memory exercises request holding and read-data capture. Comparing the two channel types brings the missed-packet path, the parked transmit idle state and automatic chaining within reach. The table also holds buffers exactly at the minimum length, buffers below it, and misaligned buffers.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_RD_HEAD, S_RD_LEN, S_RD_ALO, S_RD_AHI, S_CHK, S_RUN,
      S_WR_USED, S_WR_CMPL, S_RD_LINK, S_WR_HEAD, S_RD_WAKE, S_IRQ,
      S_RD_MISS, S_WR_MISS
   } seq_state_e;

   // control block word offsets
   localparam int unsigned CB_HEAD_OFS = 1;
   localparam int unsigned CB_WAKE_OFS = 4;
   localparam int unsigned CB_MISS_OFS = 5;
   // descriptor word offsets
   localparam int unsigned DS_LINK_OFS = 0;
   localparam int unsigned DS_CMPL_OFS = 3;
   localparam int unsigned DS_USED_OFS = 4;
   localparam int unsigned DS_LEN_OFS  = 5;
   localparam int unsigned DS_ALO_OFS  = 6;
   localparam int unsigned DS_AHI_OFS  = 7;
endpackage

// File: rtl/dcs_mem_if.sv
module dcs_mem_if #(
   parameter int unsigned AW = 16,
   parameter int unsigned DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          done,
   output logic [DW-1:0] rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ready,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata
);
   typedef enum logic [1:0] {P_IDLE, P_REQ, P_WAIT} port_state_e;

   port_state_e   pst;
   logic          we_q, done_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q, rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pst     <= P_IDLE;
         we_q    <= 1'b0;
         done_q  <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         case (pst)
            P_IDLE: if (go) begin
               we_q    <= we;
               addr_q  <= addr;
               wdata_q <= wdata;
               pst     <= P_REQ;
            end
            P_REQ: if (mem_ready) begin
               if (we_q) begin
                  done_q <= 1'b1;
                  pst    <= P_IDLE;
               end else begin
                  pst <= P_WAIT;
               end
            end
            P_WAIT: if (mem_rvalid) begin
               rdata_q <= mem_rdata;
               done_q  <= 1'b1;
               pst     <= P_IDLE;
            end
            default: pst <= P_IDLE;
         endcase
      end
   end

   assign mem_req   = (pst == P_REQ);
   assign mem_we    = we_q;
   assign mem_addr  = addr_q;
   assign mem_wdata = wdata_q;
   assign done      = done_q;
   assign rdata     = rdata_q;

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> (pst == P_IDLE)); // R10
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R10
endmodule

// File: rtl/dcs_buf_gate.sv
module dcs_buf_gate #(
   parameter int unsigned DW         = 16,
   parameter int unsigned MIN_LEN    = 4,
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic [DW-1:0] len,
   input  logic [DW-1:0] addr_lo,
   output logic          ok
);
   logic len_ok, align_ok;

   assign len_ok = (len >= DW'(MIN_LEN));

   generate
      if (ALIGN_BITS == 0) begin : g_noalign
         assign align_ok = 1'b1;
      end else begin : g_align
         assign align_ok = (addr_lo[ALIGN_BITS-1:0] == '0);
      end
   endgenerate

   assign ok = len_ok && align_ok;
endmodule

// File: rtl/dcs_chain_seq.sv
module dcs_chain_seq
   import dcs_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter int unsigned DW          = 16,
   parameter bit          IS_RX       = 1'b1,
   parameter int unsigned MIN_LEN     = 4,
   parameter int unsigned ALIGN_BITS  = 2,
   parameter logic [15:0] BADBUF_CODE = 16'h6400
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   cb_base,
   input  logic            go,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW-1:0]   mem_wdata,
   input  logic            mem_ready,
   input  logic            mem_rvalid,
   input  logic [DW-1:0]   mem_rdata,
   output logic            buf_valid,
   output logic [2*DW-1:0] buf_addr,
   output logic [DW-1:0]   buf_len,
   input  logic            dp_done,
   input  logic [DW-1:0]   dp_used,
   input  logic [DW-1:0]   dp_status,
   output logic            discard,
   output logic            irq,
   output logic [DW-1:0]   irq_mask
);
   localparam logic [DW-1:0] BAD_WORD = DW'(BADBUF_CODE);

   initial begin
      assert (AW <= DW) else $fatal(1, "pointer word narrower than address");
      assert (DW >= 16) else $fatal(1, "data word below 16 bits");
      assert (MIN_LEN > 0) else $fatal(1, "minimum length must be positive");
      assert (ALIGN_BITS < 8) else $fatal(1, "alignment too coarse");
   end

   seq_state_e    st, null_next, after_irq;
   logic          drop_bad;
   logic          issued, mem_st, m_go, m_we, m_done, buf_ok;
   logic [AW-1:0] m_addr, head;
   logic [DW-1:0] m_wdata, m_rdata;
   logic [DW-1:0] len_q, alo_q, ahi_q, used_q, cmpl_q, scratch_q, wake_q;

   generate
      if (IS_RX) begin : g_rx
         assign null_next = S_RD_MISS;
         assign after_irq = S_IDLE;
         assign drop_bad  = 1'b1;
      end else begin : g_tx
         assign null_next = S_IDLE;
         assign after_irq = S_RD_HEAD;
         assign drop_bad  = 1'b0;
      end
   endgenerate

   dcs_buf_gate #(.DW(DW), .MIN_LEN(MIN_LEN), .ALIGN_BITS(ALIGN_BITS)) u_gate (
      .len(len_q), .addr_lo(alo_q), .ok(buf_ok));

   dcs_mem_if #(.AW(AW), .DW(DW)) u_port (
      .clk(clk), .rst_n(rst_n), .go(m_go), .we(m_we), .addr(m_addr),
      .wdata(m_wdata), .done(m_done), .rdata(m_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata));

   always_comb begin
      mem_st  = 1'b1;
      m_we    = 1'b0;
      m_addr  = head;
      m_wdata = scratch_q;
      case (st)
         S_RD_HEAD: m_addr = cb_base + AW'(CB_HEAD_OFS);
         S_RD_LEN:  m_addr = head + AW'(DS_LEN_OFS);
         S_RD_ALO:  m_addr = head + AW'(DS_ALO_OFS);
         S_RD_AHI:  m_addr = head + AW'(DS_AHI_OFS);
         S_WR_USED: begin m_we = 1'b1; m_addr = head + AW'(DS_USED_OFS); m_wdata = used_q; end
         S_WR_CMPL: begin m_we = 1'b1; m_addr = head + AW'(DS_CMPL_OFS); m_wdata = cmpl_q; end
         S_RD_LINK: m_addr = head + AW'(DS_LINK_OFS);
         S_WR_HEAD: begin m_we = 1'b1; m_addr = cb_base + AW'(CB_HEAD_OFS); end
         S_RD_WAKE: m_addr = cb_base + AW'(CB_WAKE_OFS);
         S_RD_MISS: m_addr = cb_base + AW'(CB_MISS_OFS);
         S_WR_MISS: begin m_we = 1'b1; m_addr = cb_base + AW'(CB_MISS_OFS); m_wdata = scratch_q + DW'(1); end
         default:   mem_st = 1'b0;
      endcase
   end

   assign m_go = mem_st && !issued;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         issued    <= 1'b0;
         head      <= '0;
         len_q     <= '0;
         alo_q     <= '0;
         ahi_q     <= '0;
         used_q    <= '0;
         cmpl_q    <= '0;
         scratch_q <= '0;
         wake_q    <= '0;
      end else begin
         if (m_go)   issued <= 1'b1;
         if (m_done) issued <= 1'b0;
         case (st)
            S_IDLE: if (go) st <= S_RD_HEAD;
            S_RD_HEAD: if (m_done) begin
               head <= m_rdata[AW-1:0];
               st   <= (m_rdata == '0) ? null_next : S_RD_LEN;
            end
            S_RD_LEN: if (m_done) begin len_q <= m_rdata; st <= S_RD_ALO; end
            S_RD_ALO: if (m_done) begin alo_q <= m_rdata; st <= S_RD_AHI; end
            S_RD_AHI: if (m_done) begin ahi_q <= m_rdata; st <= S_CHK; end
            S_CHK: begin
               if (buf_ok) begin
                  st <= S_RUN;
               end else begin
                  used_q <= '0;
                  cmpl_q <= BAD_WORD;
                  st     <= S_WR_USED;
               end
            end
            S_RUN: if (dp_done) begin
               used_q <= dp_used;
               cmpl_q <= dp_status;
               st     <= S_WR_USED;
            end
            S_WR_USED: if (m_done) st <= S_WR_CMPL;
            S_WR_CMPL: if (m_done) st <= S_RD_LINK;
            S_RD_LINK: if (m_done) begin scratch_q <= m_rdata; st <= S_WR_HEAD; end
            S_WR_HEAD: if (m_done) st <= S_RD_WAKE;
            S_RD_WAKE: if (m_done) begin wake_q <= m_rdata; st <= S_IRQ; end
            S_IRQ:     st <= after_irq;
            S_RD_MISS: if (m_done) begin scratch_q <= m_rdata; st <= S_WR_MISS; end
            S_WR_MISS: if (m_done) st <= S_IDLE;
            default:   st <= S_IDLE;
         endcase
      end
   end

   assign buf_valid = (st == S_RUN);
   assign buf_addr  = {ahi_q, alo_q};
   assign buf_len   = len_q;
   assign irq       = (st == S_IRQ);
   assign irq_mask  = wake_q;
   assign discard   = ((st == S_WR_MISS) && m_done) ||
                      (drop_bad && (st == S_CHK) && !buf_ok);

   // records acceptance of the completion-word write for the current descriptor
   logic cmpl_seen;
   always_ff @(posedge clk) begin
      if (!rst_n)    cmpl_seen <= 1'b0;
      else if (irq)  cmpl_seen <= 1'b0;
      else if (mem_req && mem_ready && mem_we && (mem_addr == head + AW'(DS_CMPL_OFS)))
                     cmpl_seen <= 1'b1;
   end

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R6
   AST_CMPL_BEFORE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cmpl_seen); // R6
   AST_BUF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_valid && !dp_done) |=> (buf_valid && $stable(buf_addr) && $stable(buf_len))); // R2
   AST_BUF_MIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      buf_valid |-> (buf_len >= DW'(MIN_LEN))); // R3
   AST_TX_NO_MISS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && (mem_addr == cb_base + AW'(CB_MISS_OFS))) |-> IS_RX); // R8
   AST_IRQ_NOT_WITH_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
      discard |-> !irq); // R7
endmodule

// File: tb/tb_dcs_chain_seq.sv
`timescale 1ns/1ps
module tb_dcs_chain_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int checks = 0;
   int errors = 0;

   // receive channel signals
   logic        rx_go = 1'b0, rx_req, rx_we, rx_rdy, rx_rv = 1'b0;
   logic [15:0] rx_addr, rx_wd, rx_rd = '0;
   logic        rx_bv, rx_dd = 1'b0, rx_disc, rx_irq;
   logic [31:0] rx_ba;
   logic [15:0] rx_bl, rx_du = '0, rx_ds = '0, rx_mask;
   // transmit channel signals
   logic        tx_go = 1'b0, tx_req, tx_we, tx_rv = 1'b0;
   logic [15:0] tx_addr, tx_wd, tx_rd = '0;
   logic        tx_bv, tx_dd = 1'b0, tx_disc, tx_irq;
   logic [31:0] tx_ba;
   logic [15:0] tx_bl, tx_du = '0, tx_ds = '0, tx_mask;

   dcs_chain_seq #(.IS_RX(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cb_base(16'h0020), .go(rx_go),
      .mem_req(rx_req), .mem_we(rx_we), .mem_addr(rx_addr), .mem_wdata(rx_wd),
      .mem_ready(rx_rdy), .mem_rvalid(rx_rv), .mem_rdata(rx_rd),
      .buf_valid(rx_bv), .buf_addr(rx_ba), .buf_len(rx_bl),
      .dp_done(rx_dd), .dp_used(rx_du), .dp_status(rx_ds),
      .discard(rx_disc), .irq(rx_irq), .irq_mask(rx_mask));

   dcs_chain_seq #(.IS_RX(1'b0)) dut_tx (
      .clk(clk), .rst_n(rst_n), .cb_base(16'h0020), .go(tx_go),
      .mem_req(tx_req), .mem_we(tx_we), .mem_addr(tx_addr), .mem_wdata(tx_wd),
      .mem_ready(1'b1), .mem_rvalid(tx_rv), .mem_rdata(tx_rd),
      .buf_valid(tx_bv), .buf_addr(tx_ba), .buf_len(tx_bl),
      .dp_done(tx_dd), .dp_used(tx_du), .dp_status(tx_ds),
      .discard(tx_disc), .irq(tx_irq), .irq_mask(tx_mask));

   // memory models: receive side accepts on alternate cycles only
   logic [15:0] mrx [64];
   logic [15:0] mtx [64];
   logic rdy_t = 1'b0;
   bit rx_pend = 0, tx_pend = 0;
   int rx_ovl = 0, tx_ovl = 0, rx_acc = 0, tx_acc = 0;
   assign rx_rdy = rdy_t;

   always @(posedge clk) begin
      rdy_t <= ~rdy_t;
      rx_rv <= 1'b0;
      if (rx_req && rx_pend) rx_ovl++;
      if (rx_rv) rx_pend = 0;
      if (rx_req && rx_rdy) begin
         rx_acc++;
         if (rx_we) mrx[rx_addr[5:0]] = rx_wd;
         else begin rx_pend = 1; rx_rv <= 1'b1; rx_rd <= mrx[rx_addr[5:0]]; end
      end
   end

   always @(posedge clk) begin
      tx_rv <= 1'b0;
      if (tx_req && tx_pend) tx_ovl++;
      if (tx_rv) tx_pend = 0;
      if (tx_req) begin
         tx_acc++;
         if (tx_we) mtx[tx_addr[5:0]] = tx_wd;
         else begin tx_pend = 1; tx_rv <= 1'b1; tx_rd <= mtx[tx_addr[5:0]]; end
      end
   end

   // event monitors
   int rx_irq_n = 0, rx_disc_n = 0, tx_irq_n = 0, tx_disc_n = 0;
   logic [15:0] rx_mask_last = '0, tx_mask_last = '0, rx_cmpl_at_irq = '0;
   bit rx_bv_seen = 0;
   always @(negedge clk) begin
      if (rx_irq) begin rx_irq_n++; rx_mask_last = rx_mask; rx_cmpl_at_irq = mrx[6'h0B]; end
      if (rx_disc) rx_disc_n++;
      if (rx_bv) rx_bv_seen = 1;
      if (tx_irq) begin tx_irq_n++; tx_mask_last = tx_mask; end
      if (tx_disc) tx_disc_n++;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_cnt(ref int cnt, input int target);
      for (int t = 0; t < 3000 && cnt < target; t++) @(negedge clk);
   endtask

   task automatic wait_sig(ref logic s, input logic val);
      for (int t = 0; t < 3000 && s !== val; t++) @(negedge clk);
   endtask

   // {len, addr_lo, addr_hi, used, status, wake, accept}
   localparam logic [111:0] VEC [4] = '{
      {16'd8,  16'h0100, 16'h0002, 16'd5, 16'h4000, 16'h0001, 16'd1},
      {16'd4,  16'h0204, 16'h0003, 16'd4, 16'h7003, 16'h8000, 16'd1},
      {16'd3,  16'h0300, 16'h0000, 16'd2, 16'h4000, 16'h00F0, 16'd0},
      {16'd16, 16'h0102, 16'h0001, 16'd9, 16'h4000, 16'h0A0A, 16'd0}
   };

   initial begin
      for (int i = 0; i < 64; i++) begin mrx[i] = '0; mtx[i] = '0; end
      repeat (3) @(negedge clk);
      chk(!rx_req && !rx_bv && !rx_irq && !rx_disc, "R11 rx reset", {28'd0, rx_req, rx_bv, rx_irq, rx_disc}, 0);
      chk(!tx_req && !tx_bv && !tx_irq && !tx_disc, "R11 tx reset", {28'd0, tx_req, tx_bv, tx_irq, tx_disc}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // table-driven receive descriptors
      for (int i = 0; i < 4; i++) begin
         logic [15:0] len, alo, ahi, used, stat, wake, link, ecmpl, eused;
         int irq0, disc0;
         bit acc;
         len = VEC[i][111:96]; alo = VEC[i][95:80]; ahi = VEC[i][79:64];
         used = VEC[i][63:48]; stat = VEC[i][47:32]; wake = VEC[i][31:16];
         acc = VEC[i][0];
         link = 16'h0010 + 16'(i);
         ecmpl = acc ? stat : 16'h6400;
         eused = acc ? used : 16'h0000;
         mrx[6'h21] = 16'h0008; mrx[6'h24] = wake;
         mrx[6'h08] = link; mrx[6'h0B] = 16'hFFFF; mrx[6'h0C] = 16'hFFFF;
         mrx[6'h0D] = len; mrx[6'h0E] = alo; mrx[6'h0F] = ahi;
         irq0 = rx_irq_n; disc0 = rx_disc_n; rx_bv_seen = 0;
         @(negedge clk) rx_go = 1'b1;
         @(negedge clk) rx_go = 1'b0;
         if (acc) begin
            wait_sig(rx_bv, 1'b1);
            chk(rx_ba == {ahi, alo}, "R2 buf_addr", rx_ba, {ahi, alo});
            chk(rx_bl == len, "R2 buf_len", {16'd0, rx_bl}, {16'd0, len});
            repeat (3) @(negedge clk);
            chk(rx_bv && rx_ba == {ahi, alo}, "R2 held", rx_ba, {ahi, alo});
            rx_du = used; rx_ds = stat; rx_dd = 1'b1;
            @(negedge clk) rx_dd = 1'b0;
         end
         wait_cnt(rx_irq_n, irq0 + 1);
         chk(mrx[6'h0B] == ecmpl, acc ? "R4 completion" : "R3 bad completion", {16'd0, mrx[6'h0B]}, {16'd0, ecmpl});
         chk(mrx[6'h0C] == eused, acc ? "R4 used" : "R3 bad used", {16'd0, mrx[6'h0C]}, {16'd0, eused});
         chk(mrx[6'h21] == link, "R5 head advanced", {16'd0, mrx[6'h21]}, {16'd0, link});
         chk(rx_mask_last == wake, "R6 irq mask", {16'd0, rx_mask_last}, {16'd0, wake});
         chk(rx_cmpl_at_irq == ecmpl, "R6 completion before irq", {16'd0, rx_cmpl_at_irq}, {16'd0, ecmpl});
         chk(rx_disc_n == disc0 + (acc ? 0 : 1), "R3 discard count", rx_disc_n, disc0 + (acc ? 0 : 1));
         if (!acc) chk(!rx_bv_seen, "R3 not presented", {31'd0, rx_bv_seen}, 0);
      end

      // receive returns idle after irq
      begin
         int a0;
         repeat (10) @(negedge clk);
         a0 = rx_acc;
         repeat (40) @(negedge clk);
         chk(rx_acc == a0, "R9 rx idle after irq", rx_acc, a0);
      end

      // receive with no descriptor
      begin
         int irq0, disc0;
         mrx[6'h21] = 16'h0000; mrx[6'h25] = 16'h0007;
         irq0 = rx_irq_n; disc0 = rx_disc_n; rx_bv_seen = 0;
         @(negedge clk) rx_go = 1'b1;
         @(negedge clk) rx_go = 1'b0;
         wait_cnt(rx_disc_n, disc0 + 1);
         repeat (10) @(negedge clk);
         chk(mrx[6'h25] == 16'h0008, "R7 missed counter", {16'd0, mrx[6'h25]}, 32'h8);
         chk(rx_irq_n == irq0, "R7 no irq", rx_irq_n, irq0);
         chk(rx_disc_n == disc0 + 1, "R7 one discard", rx_disc_n, disc0 + 1);
         chk(!rx_bv_seen, "R1 null head presents nothing", {31'd0, rx_bv_seen}, 0);
      end

      // transmit chain of two
      begin
         int a0;
         mtx[6'h21] = 16'h0008; mtx[6'h24] = 16'h0003; mtx[6'h25] = 16'h0055;
         mtx[6'h08] = 16'h0010; mtx[6'h0D] = 16'd8;  mtx[6'h0E] = 16'h0400; mtx[6'h0F] = 16'h0000;
         mtx[6'h10] = 16'h0000; mtx[6'h15] = 16'd12; mtx[6'h16] = 16'h0800; mtx[6'h17] = 16'h0000;
         @(negedge clk) tx_go = 1'b1;
         @(negedge clk) tx_go = 1'b0;
         wait_sig(tx_bv, 1'b1);
         chk(tx_ba == 32'h0000_0400, "R2 tx first buffer", tx_ba, 32'h400);
         tx_du = 16'd6; tx_ds = 16'h4000; tx_dd = 1'b1;
         @(negedge clk) tx_dd = 1'b0;
         wait_sig(tx_bv, 1'b0);
         wait_sig(tx_bv, 1'b1);
         chk(tx_ba == 32'h0000_0800 && tx_bl == 16'd12, "R9 tx chained buffer", tx_ba, 32'h800);
         tx_du = 16'd12; tx_ds = 16'h4010; tx_dd = 1'b1;
         @(negedge clk) tx_dd = 1'b0;
         wait_cnt(tx_irq_n, 2);
         repeat (20) @(negedge clk);
         chk(tx_irq_n == 2, "R9 tx two irqs", tx_irq_n, 2);
         chk(mtx[6'h0B] == 16'h4000 && mtx[6'h0C] == 16'd6, "R4 tx first completion", {mtx[6'h0B], mtx[6'h0C]}, {16'h4000, 16'd6});
         chk(mtx[6'h13] == 16'h4010 && mtx[6'h14] == 16'd12, "R4 tx second completion", {mtx[6'h13], mtx[6'h14]}, {16'h4010, 16'd12});
         chk(mtx[6'h21] == 16'h0000, "R5 tx head null", {16'd0, mtx[6'h21]}, 0);
         chk(tx_mask_last == 16'h0003, "R6 tx irq mask", {16'd0, tx_mask_last}, 3);
         chk(mtx[6'h25] == 16'h0055 && tx_disc_n == 0, "R8 tx miss untouched", {mtx[6'h25], 16'(tx_disc_n)}, {16'h0055, 16'd0});
         // parked until a new go
         a0 = tx_acc;
         mtx[6'h21] = 16'h0008; mtx[6'h08] = 16'h0000;
         repeat (60) @(negedge clk);
         chk(tx_acc == a0 && !tx_bv, "R8 tx parked", tx_acc, a0);
         @(negedge clk) tx_go = 1'b1;
         @(negedge clk) tx_go = 1'b0;
         wait_sig(tx_bv, 1'b1);
         chk(tx_bv && tx_ba == 32'h0000_0400, "R8 tx restarted", tx_ba, 32'h400);
         tx_du = 16'd3; tx_ds = 16'h4000; tx_dd = 1'b1;
         @(negedge clk) tx_dd = 1'b0;
         wait_cnt(tx_irq_n, 3);
         chk(tx_irq_n == 3 && mtx[6'h0C] == 16'd3, "R4 tx restart completion", {16'(tx_irq_n), mtx[6'h0C]}, {16'd3, 16'd3});
      end

      chk(rx_ovl == 0 && tx_ovl == 0, "R10 single outstanding", rx_ovl + tx_ovl, 0);
      repeat (5) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule